// File: doc/BRIEF.md
# SD Card Host Register Front-End

This block sits between a 32-bit word-addressed register bus and the card-side engines of an SD card host. Software builds a command by writing its six bytes, one at a time, into a command window. The sixth byte completes the frame, which goes out to a card command engine through a valid/ready handshake. The engine answers with a reply at the moment of the handshake. The block reframes that reply into a response buffer, and software reads the buffer back one byte per read of the same window.

A separate data window turns each 32-bit write into four bytes for the card, the most significant byte first. It also packs up to four bytes arriving from the card into one word for software to read. Four small control registers hold a clock divider, the enable bits, a start word and a computed pending word. If no card is present, the command and data windows read as all ones and ignore writes.

Top module: `sdcard_reg_frontend`

## Requirements
- R1: After reset, every register reads 0, `cmd_valid` and `dtx_valid` are low, and `drx_ready` is high.
- R2: Word `k` lives at byte address `4*k`, with word 0 the divider, 1 enable, 2 pending, 3 start, 4 command and 5 data. The divider keeps the low DIV_W bits of a write, enable keeps bits 3:0 and start keeps bits 1:0, and all three read back zero-extended. An access with address bits 1:0 not zero, or to a word index of 6 or more, reads 0 and changes nothing.
- R3: The pending word uses the enable layout: bit0 command send, bit1 command receive, bit2 data send, bit3 data receive. Bits 0 and 2 always read 0. Bit 1 equals enable bit 1 and bit 3 equals enable bit 3. A write of ones to the pending word leaves this reading unchanged.
- R4: Each accepted command-window write takes `wdata[7:0]`. The sixth accepted byte raises `cmd_valid` in the next cycle, with `cmd_index` set to byte 0 bits 5:0, `cmd_arg` set to bytes 1 to 4 (byte 1 in bits 31:24), and `cmd_crc` set to byte 5. The byte count then restarts at 0.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high, the frame outputs hold their values, and command-window writes are ignored. `cmd_valid` falls in the cycle after a cycle in which it is high together with `cmd_ready`.
- R6: At the handshake, `rsp_kind` and `rsp_data` are captured, and reply byte `i` is taken from `rsp_data[127-8i -: 8]`. Kind 2 (long) gives 17 bytes: 0x3F, then reply bytes 0 to 15. Kind 1 (short) gives 6 bytes: the index, reply bytes 0 to 3, then 0x00. Kind 0 or 3 gives one byte, the index. In the short and none cases the index byte is `{2'b00, index}`.
- R7: Command-window reads return response bytes from position 0 upward. After the last byte is read, the next read returns byte 0 again. A new handshake restarts the read position at byte 0.
- R8: Once a command with index 0 has been issued, the next accepted command-window write is dropped, and the byte count does not advance.
- R9: A data-window write makes `dtx_valid` high for exactly four cycles, beginning in the next cycle. `dtx_byte` carries `wdata[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order.
- R10: A byte is taken when `drx_valid` and `drx_ready` are both high. Taken bytes fill the data word from bits 31:24 downward, and slots not yet filled read 0. `drx_ready` is low while four bytes are held. A data-window read returns the word and empties it.
- R11: While `card_present` is low, command reads return 0x000000FF, data reads return 0xFFFFFFFF, neither read changes any state, and command and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| card_present | input | 1 | A card is inserted |
| clk_div_o | output | DIV_W | Stored clock divider |
| enable_o | output | 4 | Stored enable bits |
| start_o | output | 2 | Stored start bits |
| cmd_valid | output | 1 | Command frame offered to the engine |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Sixth byte, passed as CRC |
| cmd_ready | input | 1 | Engine accepts the frame, reply valid |
| rsp_kind | input | 2 | Reply kind: 0 none, 1 short, 2 long |
| rsp_data | input | 128 | Reply bytes, first at bits 127:120 |
| dtx_valid | output | 1 | Outgoing data byte valid |
| dtx_byte | output | 8 | Outgoing data byte |
| drx_valid | input | 1 | Incoming data byte valid |
| drx_byte | input | 8 | Incoming data byte |
| drx_ready | output | 1 | Room for an incoming byte |

## Verification
Some rules hold on every cycle, and the assertions track them: the frame stays stable while waiting for `cmd_ready`, a new frame follows a command-window write, an outgoing burst follows a data-window write, the windows read as all ones with no card, the send bits of the pending word stay 0, and misaligned reads return 0. Other behaviour only shows over a sequence of accesses, so only the bench's scenarios can reveal it. This includes the byte order inside a frame, how each reply kind is reframed, where response reads wrap, the dropped write after index 0, and the word packing of incoming bytes with partial fills and back-pressure.

// File: rtl/sdfront_pkg.sv
// Package: shared constants for the SD card register front-end.
// Assumes a fixed six-byte command frame and a 32-bit register bus.
package sdfront_pkg;

    // Word offsets of the register map (word index, byte address = 4 * index)
    localparam int OFS_DIV   = 0;
    localparam int OFS_EN    = 1;
    localparam int OFS_PEND  = 2;
    localparam int OFS_START = 3;
    localparam int OFS_CMD   = 4;
    localparam int OFS_DAT   = 5;
    localparam int NUM_REGS  = 6;

    // Bit positions shared by the enable and pending words
    localparam int BIT_CMD_TX = 0;
    localparam int BIT_CMD_RX = 1;
    localparam int BIT_DAT_TX = 2;
    localparam int BIT_DAT_RX = 3;

    // Command frame geometry
    localparam int CMD_BYTES = 6;
    localparam int BUS_W     = 32;

    // Reply kinds reported by the card command engine
    localparam logic [1:0] KIND_NONE  = 2'd0;
    localparam logic [1:0] KIND_SHORT = 2'd1;
    localparam logic [1:0] KIND_LONG  = 2'd2;

    // Marker byte placed first in a long-reply response
    localparam logic [7:0] LONG_MARK = 8'h3F;

endpackage

// File: rtl/sdf_cmd_path.sv
// Module: command window and response buffer.
// Collects command bytes into a frame, offers it on a valid/ready handshake,
// reframes the reply captured at the handshake and serves it byte by byte.
// Assumes the caller has already gated the strobes with card presence.
module sdf_cmd_path
    import sdfront_pkg::*;
#(
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [7:0]            wr_byte,
    input  logic                  rd_stb,
    output logic [7:0]            rd_byte,
    output logic                  cmd_valid,
    output logic [5:0]            cmd_index,
    output logic [31:0]           cmd_arg,
    output logic [7:0]            cmd_crc,
    input  logic                  cmd_ready,
    input  logic [1:0]            rsp_kind,
    input  logic [8*LONG_LEN-1:0] rsp_data
);

    localparam int RSP_BYTES = LONG_LEN + 1;
    localparam int REPLY_W   = 8 * LONG_LEN;
    localparam int PTR_W     = $clog2(CMD_BYTES);
    localparam int LEN_W     = $clog2(RSP_BYTES + 1);
    localparam int RD_W      = $clog2(RSP_BYTES);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(CMD_BYTES - 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [5:0]       idx_q;
    logic [31:0]      arg_q;
    logic             skip_q;
    logic             accept;
    logic             handshake;

    logic [7:0]       rsp_buf  [RSP_BYTES];
    logic [7:0]       rsp_next [RSP_BYTES];
    logic [LEN_W-1:0] rsp_len;
    logic [LEN_W-1:0] len_next;
    logic [RD_W-1:0]  rd_ptr;

    assign accept    = wr_stb && !cmd_valid;
    assign handshake = cmd_valid && cmd_ready;

    // Command window: gather bytes, drop the one after index 0, issue on the sixth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            idx_q     <= '0;
            arg_q     <= '0;
            skip_q    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_index <= '0;
            cmd_arg   <= '0;
            cmd_crc   <= '0;
        end else begin
            if (handshake) begin
                cmd_valid <= 1'b0;
            end
            if (accept) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else begin
                    if (wr_ptr == '0) begin
                        idx_q <= wr_byte[5:0];
                    end else if (wr_ptr != LAST_PTR) begin
                        arg_q <= {arg_q[23:0], wr_byte};
                    end
                    if (wr_ptr == LAST_PTR) begin
                        wr_ptr    <= '0;
                        cmd_valid <= 1'b1;
                        cmd_index <= idx_q;
                        cmd_arg   <= arg_q;
                        cmd_crc   <= wr_byte;
                        skip_q    <= (idx_q == 6'd0);
                    end else begin
                        wr_ptr <= wr_ptr + PTR_W'(1);
                    end
                end
            end
        end
    end

    // Reply reframing: build the next response image from the captured reply
    always_comb begin
        rsp_next[0] = (rsp_kind == KIND_LONG) ? LONG_MARK : {2'b00, cmd_index};
        for (int i = 1; i < RSP_BYTES; i++) begin
            if (rsp_kind == KIND_LONG) begin
                rsp_next[i] = rsp_data[REPLY_W-1-8*(i-1) -: 8];
            end else if (rsp_kind == KIND_SHORT && i <= SHORT_LEN) begin
                rsp_next[i] = rsp_data[REPLY_W-1-8*(i-1) -: 8];
            end else begin
                rsp_next[i] = 8'h00;
            end
        end
        case (rsp_kind)
            KIND_LONG:  len_next = LEN_W'(RSP_BYTES);
            KIND_SHORT: len_next = LEN_W'(SHORT_LEN + 2);
            default:    len_next = LEN_W'(1);
        endcase
    end

    // Response buffer: load at the handshake, step the read position on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RSP_BYTES; i++) begin
                rsp_buf[i] <= 8'h00;
            end
            rsp_len <= '0;
            rd_ptr  <= '0;
        end else if (handshake) begin
            for (int i = 0; i < RSP_BYTES; i++) begin
                rsp_buf[i] <= rsp_next[i];
            end
            rsp_len <= len_next;
            rd_ptr  <= '0;
        end else if (rd_stb) begin
            if ((LEN_W'(rd_ptr) + LEN_W'(1)) >= rsp_len) begin
                rd_ptr <= '0;
            end else begin
                rd_ptr <= rd_ptr + RD_W'(1);
            end
        end
    end

    // Read port: the byte at the current read position
    assign rd_byte = rsp_buf[rd_ptr];

endmodule

// File: rtl/sdf_data_pack.sv
// Module: data window byte packer.
// Splits a written word into an outgoing byte burst, most significant first,
// and packs incoming bytes into a word, the first byte in the top slot.
// Assumes the outgoing side accepts one byte per cycle without back-pressure.
module sdf_data_pack #(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [8*BYTES-1:0] wr_word,
    output logic               dtx_valid,
    output logic [7:0]         dtx_byte,
    input  logic               rd_stb,
    output logic [8*BYTES-1:0] rd_word,
    input  logic               drx_valid,
    input  logic [7:0]         drx_byte,
    output logic               drx_ready
);

    localparam int WORD_W = 8 * BYTES;
    localparam int CNT_W  = $clog2(BYTES + 1);

    logic [WORD_W-1:0] tx_sh;
    logic [CNT_W-1:0]  tx_left;
    logic [WORD_W-1:0] rx_word;
    logic [CNT_W-1:0]  rx_cnt;
    logic              take;

    // Serializer: load on a write, then shift one byte out per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            tx_left <= '0;
        end else if (wr_stb) begin
            tx_sh   <= wr_word;
            tx_left <= CNT_W'(BYTES);
        end else if (tx_left != '0) begin
            tx_sh   <= tx_sh << 8;
            tx_left <= tx_left - CNT_W'(1);
        end
    end

    assign dtx_valid = (tx_left != '0);
    assign dtx_byte  = tx_sh[WORD_W-1 -: 8];

    assign drx_ready = (rx_cnt < CNT_W'(BYTES));
    assign take      = drx_valid && drx_ready;

    // Assembler: fill slots from the top, empty on a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_word <= '0;
            rx_cnt  <= '0;
        end else if (rd_stb) begin
            rx_word <= take ? {drx_byte, {(WORD_W-8){1'b0}}} : '0;
            rx_cnt  <= take ? CNT_W'(1) : '0;
        end else if (take) begin
            for (int k = 0; k < BYTES; k++) begin
                if (rx_cnt == CNT_W'(k)) begin
                    rx_word[WORD_W-1-8*k -: 8] <= drx_byte;
                end
            end
            rx_cnt <= rx_cnt + CNT_W'(1);
        end
    end

    assign rd_word = rx_word;

endmodule

// File: rtl/sdcard_reg_frontend.sv
// Module: SD card register front-end (top).
// Decodes word-aligned register accesses, holds the divider, enable and start
// words, computes the pending word, and routes the command and data windows.
// Assumes single-cycle accesses with read data sampled in the access cycle.
module sdcard_reg_frontend
    import sdfront_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_present,
    output logic [DIV_W-1:0]  clk_div_o,
    output logic [3:0]        enable_o,
    output logic [1:0]        start_o,
    output logic              cmd_valid,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    output logic [7:0]        cmd_crc,
    input  logic              cmd_ready,
    input  logic [1:0]        rsp_kind,
    input  logic [127:0]      rsp_data,
    output logic              dtx_valid,
    output logic [7:0]        dtx_byte,
    input  logic              drx_valid,
    input  logic [7:0]        drx_byte,
    output logic              drx_ready
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]    word_idx;
    logic                aligned;
    logic [NUM_REGS-1:0] hit;
    logic                wr_any;
    logic                rd_any;
    logic                cmd_wr;
    logic                cmd_rd;
    logic                dat_wr;
    logic                dat_rd;
    logic [7:0]          rsp_byte;
    logic [BUS_W-1:0]    dat_word;
    logic [3:0]          pend_view;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_any   = bus_en && bus_we;
    assign rd_any   = bus_en && !bus_we;

    // One select line per register word
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign hit[r] = bus_en && aligned && (word_idx == IDX_W'(r));
    end

    assign cmd_wr = hit[OFS_CMD] && bus_we  && card_present;
    assign cmd_rd = hit[OFS_CMD] && !bus_we && card_present;
    assign dat_wr = hit[OFS_DAT] && bus_we  && card_present;
    assign dat_rd = hit[OFS_DAT] && !bus_we && card_present;

    // Control words: divider, enable and start storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_div_o <= '0;
            enable_o  <= '0;
            start_o   <= '0;
        end else if (wr_any) begin
            if (hit[OFS_DIV])   clk_div_o <= bus_wdata[DIV_W-1:0];
            if (hit[OFS_EN])    enable_o  <= bus_wdata[3:0];
            if (hit[OFS_START]) start_o   <= bus_wdata[1:0];
        end
    end

    // Pending view: send bits never pend, receive bits follow their enables
    always_comb begin
        pend_view             = 4'b0000;
        pend_view[BIT_CMD_RX] = enable_o[BIT_CMD_RX];
        pend_view[BIT_DAT_RX] = enable_o[BIT_DAT_RX];
        pend_view[BIT_CMD_TX] = 1'b0;
        pend_view[BIT_DAT_TX] = 1'b0;
    end

    // Read mux: select the addressed word during a read access
    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            if (hit[OFS_DIV])   bus_rdata = {{(32-DIV_W){1'b0}}, clk_div_o};
            if (hit[OFS_EN])    bus_rdata = {28'd0, enable_o};
            if (hit[OFS_PEND])  bus_rdata = {28'd0, pend_view};
            if (hit[OFS_START]) bus_rdata = {30'd0, start_o};
            if (hit[OFS_CMD])   bus_rdata = card_present ? {24'd0, rsp_byte} : 32'h0000_00FF;
            if (hit[OFS_DAT])   bus_rdata = card_present ? dat_word : 32'hFFFF_FFFF;
        end
    end

    sdf_cmd_path #(
        .LONG_LEN  (16),
        .SHORT_LEN (4)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (cmd_wr),
        .wr_byte   (bus_wdata[7:0]),
        .rd_stb    (cmd_rd),
        .rd_byte   (rsp_byte),
        .cmd_valid (cmd_valid),
        .cmd_index (cmd_index),
        .cmd_arg   (cmd_arg),
        .cmd_crc   (cmd_crc),
        .cmd_ready (cmd_ready),
        .rsp_kind  (rsp_kind),
        .rsp_data  (rsp_data)
    );

    sdf_data_pack #(
        .BYTES (BUS_W / 8)
    ) u_dat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (dat_wr),
        .wr_word   (bus_wdata),
        .dtx_valid (dtx_valid),
        .dtx_byte  (dtx_byte),
        .rd_stb    (dat_rd),
        .rd_word   (dat_word),
        .drx_valid (drx_valid),
        .drx_byte  (drx_byte),
        .drx_ready (drx_ready)
    );

endmodule

// File: rtl/sdf_checker.sv
// Module: property checker for the SD card register front-end.
// Watches the top-level ports only; bound to every instance of the top.
module sdf_checker
    import sdfront_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              card_present,
    input logic              cmd_valid,
    input logic [5:0]        cmd_index,
    input logic [31:0]       cmd_arg,
    input logic [7:0]        cmd_crc,
    input logic              cmd_ready,
    input logic              dtx_valid
);

    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND * 4);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD * 4);
    localparam logic [ADDR_W-1:0] A_DAT  = ADDR_W'(OFS_DAT * 4);

    // R5: an unaccepted frame stays offered and unchanged
    assert_frame_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index)
                                       && $stable(cmd_arg) && $stable(cmd_crc)));

    // R5: an accepted frame is withdrawn in the next cycle
    assert_frame_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R4: a new frame only follows a command-window write with a card present
    assert_issue_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(bus_en && bus_we && bus_addr == A_CMD && card_present));

    // R9: an outgoing burst only starts after a data-window write
    assert_burst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtx_valid) |-> $past(bus_en && bus_we && bus_addr == A_DAT && card_present));

    // R11: with no card the command window reads as 0xFF
    assert_absent_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == A_CMD && !card_present) |-> bus_rdata == 32'h0000_00FF);

    // R11: with no card the data window reads as all ones
    assert_absent_dat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == A_DAT && !card_present) |-> bus_rdata == 32'hFFFF_FFFF);

    // R3: send bits of the pending word never read as set
    assert_pend_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == A_PEND) |->
        (bus_rdata[BIT_CMD_TX] == 1'b0 && bus_rdata[BIT_DAT_TX] == 1'b0 && bus_rdata[31:4] == 28'd0));

    // R2: misaligned reads return zero
    assert_misaligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);

endmodule

bind sdcard_reg_frontend sdf_checker #(.ADDR_W(ADDR_W)) u_sdf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .card_present (card_present),
    .cmd_valid    (cmd_valid),
    .cmd_index    (cmd_index),
    .cmd_arg      (cmd_arg),
    .cmd_crc      (cmd_crc),
    .cmd_ready    (cmd_ready),
    .dtx_valid    (dtx_valid)
);

// File: tb/sdcard_reg_frontend_bench.sv
`timescale 1ns/1ps
module sdcard_reg_frontend_bench;

    localparam int ADDR_W = 5;
    localparam int DIV_W  = 16;
    localparam logic [4:0] A_DIV = 5'd0, A_EN = 5'd4, A_PEND = 5'd8,
                           A_START = 5'd12, A_CMD = 5'd16, A_DAT = 5'd20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         card_present = 1'b1;
    logic [15:0]  clk_div_o;
    logic [3:0]   enable_o;
    logic [1:0]   start_o;
    logic         cmd_valid;
    logic [5:0]   cmd_index;
    logic [31:0]  cmd_arg;
    logic [7:0]   cmd_crc;
    logic         cmd_ready = 1'b0;
    logic [1:0]   rsp_kind = '0;
    logic [127:0] rsp_data = '0;
    logic         dtx_valid;
    logic [7:0]   dtx_byte;
    logic         drx_valid = 1'b0;
    logic [7:0]   drx_byte = '0;
    logic         drx_ready;

    int checks = 0;
    int errors = 0;
    bit skip_next = 1'b0;

    always #2 clk = ~clk;

    sdcard_reg_frontend #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_sdcard_reg_frontend (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    function automatic int exp_len(input logic [1:0] k);
        return (k == 2'd2) ? 17 : (k == 2'd1) ? 6 : 1;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [1:0] k, input logic [5:0] idx,
                                            input logic [127:0] d, input int i);
        if (i == 0) return (k == 2'd2) ? 8'h3F : {2'b00, idx};
        if (k == 2'd2 || (k == 2'd1 && i <= 4)) return d[127-8*(i-1) -: 8];
        return 8'h00;
    endfunction

    // Writes a frame (plus a dropped byte when one is due) and checks the offered fields
    task automatic send_frame(input logic [7:0] b [6], input string req);
        if (skip_next) begin
            bus_write(A_CMD, 32'h0000_00EE);
            skip_next = 1'b0;
        end
        for (int i = 0; i < 6; i++) bus_write(A_CMD, {24'hABCDEF, b[i]});
        check(cmd_valid === 1'b1, req, {31'd0, cmd_valid}, 32'd1);
        check(cmd_index === b[0][5:0], req, {26'd0, cmd_index}, {26'd0, b[0][5:0]});
        check(cmd_arg === {b[1], b[2], b[3], b[4]}, req, cmd_arg, {b[1], b[2], b[3], b[4]});
        check(cmd_crc === b[5], req, {24'd0, cmd_crc}, {24'd0, b[5]});
        if (b[0][5:0] == 6'd0) skip_next = 1'b1;
    endtask

    task automatic answer(input logic [1:0] k, input logic [127:0] d);
        cmd_ready = 1'b1; rsp_kind = k; rsp_data = d;
        @(negedge clk);
        cmd_ready = 1'b0;
        check(cmd_valid === 1'b0, "R5", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic read_response(input logic [1:0] k, input logic [5:0] idx, input logic [127:0] d);
        logic [31:0] r;
        int n;
        n = exp_len(k);
        for (int i = 0; i <= n; i++) begin
            bus_read(A_CMD, r);
            check(r === {24'd0, exp_byte(k, idx, d, i % n)}, (i == n) ? "R7" : "R6",
                  r, {24'd0, exp_byte(k, idx, d, i % n)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0]  r;
        logic [7:0]   fr [6];
        logic [127:0] d;
        logic [1:0]   k;
        int           seed;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(cmd_valid === 1'b0 && dtx_valid === 1'b0 && drx_ready === 1'b1, "R1",
              {29'd0, cmd_valid, dtx_valid, drx_ready}, 32'd1);
        foreach (fr[i]) fr[i] = 8'h00;
        for (int a = 0; a < 6; a++) begin
            bus_read(5'(a * 4), r);
            check(r === 32'd0, "R1", r, 32'd0);
        end

        // R2: widths of the stored words, misaligned and unmapped accesses
        bus_write(A_DIV, 32'h1234_ABCD);
        bus_read(A_DIV, r);   check(r === 32'h0000_ABCD, "R2", r, 32'h0000_ABCD);
        bus_write(A_START, 32'hFFFF_FFFF);
        bus_read(A_START, r); check(r === 32'h3, "R2", r, 32'h3);
        bus_write(5'd1, 32'h0000_5555);
        bus_read(A_DIV, r);   check(r === 32'h0000_ABCD, "R2", r, 32'h0000_ABCD);
        bus_read(5'd5, r);    check(r === 32'd0, "R2", r, 32'd0);
        bus_read(5'd24, r);   check(r === 32'd0, "R2", r, 32'd0);

        // R3: pending follows the receive enables, writes to it change nothing
        bus_write(A_EN, 32'hFFFF_FFFF);
        bus_read(A_EN, r);    check(r === 32'hF, "R2", r, 32'hF);
        bus_read(A_PEND, r);  check(r === 32'hA, "R3", r, 32'hA);
        bus_write(A_PEND, 32'hF);
        bus_read(A_PEND, r);  check(r === 32'hA, "R3", r, 32'hA);
        bus_write(A_EN, 32'h5);
        bus_read(A_PEND, r);  check(r === 32'h0, "R3", r, 32'h0);
        bus_write(A_EN, 32'h2);
        bus_read(A_PEND, r);  check(r === 32'h2, "R3", r, 32'h2);

        // R4, R5, R6, R7: directed short reply with a held handshake
        fr = '{8'h51, 8'h12, 8'h34, 8'h56, 8'h78, 8'hAB};
        send_frame(fr, "R4");
        bus_write(A_CMD, 32'h0000_0077);
        repeat (2) @(negedge clk);
        check(cmd_valid === 1'b1 && cmd_arg === 32'h1234_5678, "R5", cmd_arg, 32'h1234_5678);
        d = {32'hDEAD_BEEF, 96'd0};
        answer(2'd1, d);
        read_response(2'd1, 6'h11, d);

        // R8: index 0 command, then the next byte is dropped
        fr = '{8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h95};
        send_frame(fr, "R4");
        answer(2'd0, '0);
        read_response(2'd0, 6'h00, '0);
        fr = '{8'h48, 8'h00, 8'h00, 8'h01, 8'hAA, 8'h87};
        send_frame(fr, "R8");
        answer(2'd3, '0);
        read_response(2'd0, 6'h08, '0);

        // R11: no card present
        card_present = 1'b0;
        bus_read(A_CMD, r);  check(r === 32'h0000_00FF, "R11", r, 32'hFF);
        bus_read(A_DAT, r);  check(r === 32'hFFFF_FFFF, "R11", r, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) bus_write(A_CMD, 32'h0000_0041);
        check(cmd_valid === 1'b0, "R11", {31'd0, cmd_valid}, 32'd0);
        bus_write(A_DAT, 32'h0102_0304);
        check(dtx_valid === 1'b0, "R11", {31'd0, dtx_valid}, 32'd0);
        card_present = 1'b1;
        bus_read(A_CMD, r);  check(r === 32'h0000_0008, "R11", r, 32'h8);

        // R10: partial fill, full fill with back-pressure
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); drx_valid = 1'b1; drx_byte = 8'hC0 + 8'(i);
        end
        @(negedge clk); drx_valid = 1'b0;
        bus_read(A_DAT, r);  check(r === 32'hC0C1_0000, "R10", r, 32'hC0C1_0000);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); drx_valid = 1'b1; drx_byte = 8'h10 + 8'(i);
        end
        @(negedge clk); drx_valid = 1'b0;
        check(drx_ready === 1'b0, "R10", {31'd0, drx_ready}, 32'd0);
        bus_read(A_DAT, r);  check(r === 32'h1011_1213, "R10", r, 32'h1011_1213);
        check(drx_ready === 1'b1, "R10", {31'd0, drx_ready}, 32'd1);

        // R9, R10: random words both ways
        for (int n = 0; n < 20; n++) begin
            logic [31:0] w;
            w = $urandom;
            bus_write(A_DAT, w);
            for (int b = 0; b < 4; b++) begin
                check(dtx_valid === 1'b1 && dtx_byte === w[31-8*b -: 8], "R9",
                      {23'd0, dtx_valid, dtx_byte}, {23'd0, 1'b1, w[31-8*b -: 8]});
                @(negedge clk);
            end
            check(dtx_valid === 1'b0, "R9", {31'd0, dtx_valid}, 32'd0);
            w = $urandom;
            for (int b = 0; b < 4; b++) begin
                drx_valid = 1'b1; drx_byte = w[31-8*b -: 8];
                @(negedge clk);
            end
            drx_valid = 1'b0;
            bus_read(A_DAT, r);  check(r === w, "R10", r, w);
        end

        // R4, R6, R7, R8: random commands with random reply kinds and delays
        for (int n = 0; n < 40; n++) begin
            foreach (fr[i]) fr[i] = 8'($urandom);
            if (n % 7 == 3) fr[0] = 8'h00;
            k = 2'($urandom_range(0, 2));
            d = {$urandom, $urandom, $urandom, $urandom};
            send_frame(fr, (n % 7 == 4) ? "R8" : "R4");
            repeat ($urandom_range(0, 3)) @(negedge clk);
            answer(k, d);
            read_response(k, fr[0][5:0], d);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule